// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

The block timestamps signal transitions on up to four independent input pins. A shared timebase counts ticks of a programmable prescaler while capture is globally enabled. Each channel carries a two-bit edge-select code that chooses rising edges, falling edges, both edges or none. When a chosen edge arrives, the channel stores the current timebase count and raises its pending flag. Pending flags are masked per channel onto one interrupt line and are cleared by writing a mask.

Software measures high and low phases by arming a channel for rising edges and reading the stored count. It then flips the code to falling, which is an XOR with 3, and takes the difference of the two counts. Turning counts into time units is left to software. Pins are asynchronous and are resynchronized inside the block.

Top module: `input_capture_unit`

## Requirements
- R1: After reset every register reads zero (control, interrupt mask, pending status, all edge-select and all capture-value registers) and irq_o is low.
- R2: Edge-select code 1 captures only rising edges, 2 only falling edges and 3 both. Code 0 never captures and never sets the pending bit, even with capture enabled.
- R3: With prescale 0 the timebase advances every clock, so two captures on one channel differ by exactly the number of clock cycles between the two pin transitions.
- R4: With prescale value P in control bits 8:4, the timebase advances once every P+1 clocks, so a window of k*(P+1) cycles yields a capture difference of k.
- R5: While capture enable (control bit 10) is 0, no edge is captured, no pending bit is set and the timebase holds its value.
- R6: A capture on channel x sets bit x+1 of the status register (0x58). irq_o is high exactly when some status bit is set together with the same bit of the interrupt mask register (0x54).
- R7: A write to the acknowledge address (0x5C) clears exactly those status bits that are set in the written value (full mask 0x1FF) and leaves the others unchanged.
- R8: When a capture and an acknowledge of the same channel fall in the same clock cycle, the pending bit stays set.
- R9: A pin transition applied between clock edges sets the pending bit at the third rising clock edge after it, not earlier.
- R10: Register readback: capture value of channel x at 0x10+4x, edge select at 0x30+4x (bits 1:0), control at 0x50 returns only bits 8:4 and 10, the mask returns only bits 4:1, the acknowledge address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_in_i | input | NUM_CH | Asynchronous capture pins, one per channel |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write qualifier for the access |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Masked OR of the pending bits |

## Verification
The pending-bit update can see a new capture and a software acknowledge of the same channel in one cycle. The bench times an acknowledge write so that it is sampled on the exact clock edge where a synchronized rising edge is captured, three edges after the pin moves. It then reads the status register and expects the bit to remain set, so no event is lost.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam int CAP_BASE  = 'h10;
  localparam int SEL_BASE  = 'h30;
  localparam int CTRL_ADDR = 'h50;
  localparam int IEN_ADDR  = 'h54;
  localparam int STA_ADDR  = 'h58;
  localparam int ACK_ADDR  = 'h5C;
  localparam int REG_STRIDE = 4;

  localparam int PSC_LSB  = 4;
  localparam int RUN_BIT  = 10;
  localparam int STAT_LSB = 1;
  localparam int MAX_CH   = 4;
endpackage

// File: rtl/ic_sync_edge.sv
module ic_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int PIPE_W = STAGES + 1;

  // pipe[STAGES-1] is the synchronized sample, pipe[STAGES] the previous one
  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[PIPE_W-2:0], pin_i};
  end

  assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/ic_timebase.sv
module ic_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [PSC_W-1:0] div_q;
  logic             tick;

  // >= keeps the divider bounded if the prescale shrinks mid-period
  assign tick = run_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      count_o <= '0;
    end else if (!run_i) begin
      div_q   <= '0;
    end else if (tick) begin
      div_q   <= '0;
      count_o <= count_o + 1'b1;  // wraps silently
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  a_r5_frozen_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_o));

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/ic_channel.sv
module ic_channel
  import ic_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  edge_sel_e        sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] value_o
);
  assign hit_o = run_i && ((rise_i && sel_i[0]) || (fall_i && sel_i[1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    value_o <= '0;
    else if (hit_o) value_o <= count_i;
  end

  a_r2_off_keeps_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_OFF) |=> $stable(value_o));

  a_r5_idle_keeps_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(value_o));
endmodule

// File: rtl/input_capture_unit.sv
module input_capture_unit
  import ic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cap_in_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(STA_ADDR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ACK_ADDR);

  logic              wr_en;
  logic              run_q;
  logic [PSC_W-1:0]  psc_q;
  logic [NUM_CH-1:0] ien_q;
  logic [NUM_CH-1:0] status_q;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] ack_mask;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap_val [NUM_CH];
  edge_sel_e         sel_q   [NUM_CH];

  assign wr_en = bus_req_i && bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      psc_q <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      if (bus_addr_i == A_CTRL) begin
        psc_q <= bus_wdata_i[PSC_LSB +: PSC_W];
        run_q <= bus_wdata_i[RUN_BIT];
      end
      if (bus_addr_i == A_IEN) ien_q <= bus_wdata_i[STAT_LSB +: NUM_CH];
    end
  end

  assign ack_mask = (wr_en && bus_addr_i == A_ACK) ? bus_wdata_i[STAT_LSB +: NUM_CH] : '0;

  // new capture wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~ack_mask) | hit;
  end

  assign irq_o = |(status_q & ien_q);

  ic_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .psc_i   (psc_q),
    .count_o (count)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_BASE + REG_STRIDE * k);
    logic rise, fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           sel_q[k] <= EDGE_OFF;
      else if (wr_en && bus_addr_i == A_SEL) sel_q[k] <= edge_sel_e'(bus_wdata_i[1:0]);
    end

    ic_sync_edge #(.STAGES(2)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_in_i[k]),
      .rise_o (rise),
      .fall_o (fall)
    );

    ic_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_q),
      .sel_i   (sel_q[k]),
      .rise_i  (rise),
      .fall_i  (fall),
      .count_i (count),
      .hit_o   (hit[k]),
      .value_o (cap_val[k])
    );

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[k] |=> status_q[k]);

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_mask[k] && !hit[k]) |=> !status_q[k]);

    a_r2_no_capture_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q[k] == EDGE_OFF && !status_q[k]) |=> !status_q[k]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL) begin
      bus_rdata_o[PSC_LSB +: PSC_W] = psc_q;
      bus_rdata_o[RUN_BIT]          = run_q;
    end else if (bus_addr_i == A_IEN) begin
      bus_rdata_o[STAT_LSB +: NUM_CH] = ien_q;
    end else if (bus_addr_i == A_STA) begin
      bus_rdata_o[STAT_LSB +: NUM_CH] = status_q;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (bus_addr_i == ADDR_W'(CAP_BASE + REG_STRIDE * k))
          bus_rdata_o = DATA_W'(cap_val[k]);
        if (bus_addr_i == ADDR_W'(SEL_BASE + REG_STRIDE * k))
          bus_rdata_o = DATA_W'(sel_q[k]);
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i};

  a_r6_masked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  a_r6_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0) |-> !irq_o);
endmodule

// File: tb/tb_input_capture_unit.sv
`timescale 1ns/1ps
module tb_input_capture_unit;
  localparam logic [7:0] A_CAP  = 8'h10;
  localparam logic [7:0] A_SEL  = 8'h30;
  localparam logic [7:0] A_CTRL = 8'h50;
  localparam logic [7:0] A_IEN  = 8'h54;
  localparam logic [7:0] A_STA  = 8'h58;
  localparam logic [7:0] A_ACK  = 8'h5C;
  localparam logic [31:0] RUN   = 32'h400;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  pins = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  input_capture_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .cap_in_i(pins),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 ien", A_IEN, 0);
    chk_reg("R1 status", A_STA, 0);
    for (int k = 0; k < 4; k++) begin
      chk_reg("R1 cap", A_CAP + 8'(4*k), 0);
      chk_reg("R1 sel", A_SEL + 8'(4*k), 0);
    end
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_disabled;
    wr(A_CTRL, 0);
    wr(A_SEL, 3);
    pins[0] = 1'b1; tick(5);
    pins[0] = 1'b0; tick(5);
    chk_reg("R5 no status", A_STA, 0);
    chk_reg("R5 no capture", A_CAP, 0);
    wr(A_SEL, 0);
  endtask

  task automatic edge_case(input logic [1:0] code, input logic [31:0] on_rise, input logic [31:0] on_fall);
    wr(A_SEL, 32'(code));
    pins[0] = 1'b1; tick(4);
    chk_reg($sformatf("R2 code%0d rise", code), A_STA, on_rise);
    wr(A_ACK, 32'h1FF);
    pins[0] = 1'b0; tick(4);
    chk_reg($sformatf("R2 code%0d fall", code), A_STA, on_fall);
    wr(A_ACK, 32'h1FF);
  endtask

  task automatic t_edges;
    wr(A_CTRL, RUN);
    edge_case(2'd1, 32'h2, 32'h0);
    edge_case(2'd2, 32'h0, 32'h2);
    edge_case(2'd0, 32'h0, 32'h0);
    edge_case(2'd3, 32'h2, 32'h2);
    wr(A_SEL, 0);
  endtask

  task automatic t_measure(input string tag, input int ch, input int psc, input int n, input int exp);
    logic [31:0] a, b;
    logic [7:0] sa, ca;
    sa = A_SEL + 8'(4*ch);
    ca = A_CAP + 8'(4*ch);
    wr(A_CTRL, RUN | 32'(psc << 4));
    wr(sa, 1);
    pins[ch] = 1'b1; tick(4);
    rd(ca, a);
    wr(sa, 2);
    tick(n - 5);
    pins[ch] = 1'b0; tick(5);
    rd(ca, b);
    chk(tag, b - a, 32'(exp));
    wr(sa, 0);
    wr(A_ACK, 32'h1FF);
  endtask

  task automatic t_irq;
    wr(A_CTRL, RUN);
    wr(A_IEN, 0);
    wr(A_SEL + 8'd8, 1);
    pins[2] = 1'b1; tick(4);
    chk_reg("R6 status bit3", A_STA, 32'h8);
    chk("R6 irq masked", 32'(irq), 0);
    wr(A_IEN, 32'h8);
    #1 chk("R6 irq unmasked", 32'(irq), 1);
    wr(A_ACK, 32'h8);
    #1 chk("R6 irq after ack", 32'(irq), 0);
    pins[2] = 1'b0; tick(4);
    chk_reg("R6 falling ignored", A_STA, 0);
    wr(A_IEN, 0);
    wr(A_SEL + 8'd8, 0);
  endtask

  task automatic t_partial_ack;
    wr(A_SEL, 1);
    wr(A_SEL + 8'd12, 1);
    pins[0] = 1'b1; pins[3] = 1'b1; tick(4);
    chk_reg("R7 both pending", A_STA, 32'h12);
    wr(A_ACK, 32'h2);
    chk_reg("R7 partial ack", A_STA, 32'h10);
    wr(A_ACK, 32'h1FF);
    chk_reg("R7 full ack", A_STA, 0);
    pins[0] = 1'b0; pins[3] = 1'b0; tick(4);
    wr(A_SEL, 0);
    wr(A_SEL + 8'd12, 0);
  endtask

  task automatic t_latency;
    wr(A_SEL + 8'd4, 1);
    pins[1] = 1'b1; tick(2);
    chk_reg("R9 not before third edge", A_STA, 0);
    tick(1);
    chk_reg("R9 set at third edge", A_STA, 32'h4);
    wr(A_ACK, 32'h1FF);
    pins[1] = 1'b0; tick(4);
  endtask

  task automatic t_collision;
    chk_reg("R8 clean start", A_STA, 0);
    pins[1] = 1'b1; tick(2);
    wr(A_ACK, 32'h1FF);
    chk_reg("R8 capture beats ack", A_STA, 32'h4);
    wr(A_ACK, 32'h1FF);
    chk_reg("R8 later ack clears", A_STA, 0);
    pins[1] = 1'b0; tick(4);
    wr(A_SEL + 8'd4, 0);
  endtask

  task automatic t_readback;
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk_reg("R10 ctrl fields", A_CTRL, 32'h5F0);
    wr(A_SEL + 8'd12, 32'hFFFF_FFFD);
    chk_reg("R10 sel width", A_SEL + 8'd12, 32'h1);
    wr(A_IEN, 32'hFFFF_FFFF);
    chk_reg("R10 ien bits", A_IEN, 32'h1E);
    chk_reg("R10 ack reads zero", A_ACK, 0);
    wr(A_IEN, 0);
    wr(A_SEL + 8'd12, 0);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_disabled();
    t_edges();
    t_measure("R3 high time 20", 1, 0, 20, 20);
    t_measure("R3 high time 7", 3, 0, 7, 7);
    t_measure("R4 prescale 3", 0, 3, 24, 6);
    t_measure("R4 prescale 31", 2, 31, 96, 3);
    wr(A_CTRL, RUN);
    t_irq();
    t_partial_ack();
    t_latency();
    t_collision();
    t_readback();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule